// File: doc/BRIEF.md
# Write-Through Snooping Data Cache

This block is a small direct-mapped data cache that sits between one processor and a shared, atomic system bus. Every store goes straight to memory over the bus, and a store that misses leaves the cache untouched. Loads that find their line present are answered locally. Loads that miss fetch the word over the bus and keep it.

Coherence with other caches on the same bus comes from snooping. The cache watches each completed bus transaction issued by another agent. A foreign write to an address it holds drops that line to the Invalid state, so its next load fetches the fresh value. Each line has only two states, Valid and Invalid. Invalid stands both for a line that was knocked out by a snoop and for a line that was never filled.

The processor sees a simple request/ready port with one request outstanding. Ready stays low while the cache waits for the bus or for read data.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `cpu_ready` and `bus_req` are low and `bus_cmd` is idle (2'b00).
- R2: A load whose line is Invalid or holds another tag issues exactly one bus read (`bus_cmd` = 2'b01) to the load address. It returns the word delivered with `bus_ack` and leaves that line Valid with the new tag.
- R3: A load that finds its line Valid with a matching tag returns the cached word and issues no bus transaction.
- R4: Every store issues exactly one bus write (`bus_cmd` = 2'b10) carrying its address and data. A store that hits also updates the cached word, so a later local load returns the stored value.
- R5: A store that misses allocates nothing: the line stays as it was, and a later load of that address misses.
- R6: A snooped write (`snp_valid` and `snp_write` high) to an address held Valid makes the line Invalid. The next local load of that address goes to the bus and returns the value that write stored.
- R7: A snooped read (`snp_valid` high, `snp_write` low) changes no line state: a Valid line still hits afterwards.
- R8: A load miss must still complete when a snooped write to the same address arrives while the load waits for the bus or for its fill. The load returns the filled word, the line is left Invalid, and the next load of that address misses.
- R9: `bus_req` stays high from the start of a transaction until its `bus_ack`. `bus_cmd` is non-idle only while `bus_gnt` is high. A cache has at most one transaction in flight.
- R10: `cpu_ready` is a one-cycle pulse that ends each request, and it is never high while `bus_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_ready` |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_cmd | output | 2 | 00 idle, 01 read, 10 write |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Data phase complete, one cycle |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| snp_valid | input | 1 | A transaction by another agent completes this cycle |
| snp_write | input | 1 | That transaction is a write |
| snp_addr | input | ADDR_W | Its address |

## Verification
The assertions assume that the arbiter holds `bus_gnt` for as long as the owning cache keeps `bus_req` high. They also assume that `bus_ack` comes only to the granted cache and only after it has driven a command, and that snoop inputs report other agents' transactions only, never this cache's own. The bench's bus model arbitrates between two caches, releases the grant only when the owner drops its request, and feeds each cache the other's completed transactions as snoops, so all of these hold by design. Random operations are issued one at a time, so a shadow model of line state can predict hits and misses. The snoop-during-fill race is produced in one directed sequence where the second cache already owns the bus.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10
  } bus_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_ARB,
    ST_XFER,
    ST_RESP
  } ctl_state_e;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
  parameter int LINES = 16,
  parameter int TAG_W = 8,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_valid,
  input  logic             snp_en,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [TAG_W-1:0] snp_tag
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [LINES-1:0] vld_q;
  logic             kill;

  assign lk_hit = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign kill   = snp_en && vld_q[snp_idx] && (tag_q[snp_idx] == snp_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (kill) vld_q[snp_idx] <= 1'b0;
      if (fill_en) vld_q[fill_idx] <= fill_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) tag_q[fill_idx] <= fill_tag;
  end

  logic             kill_q;
  logic [IDX_W-1:0] kidx_q;
  logic [TAG_W-1:0] ktag_q;
  always_ff @(posedge clk) begin
    if (rst) kill_q <= 1'b0;
    else     kill_q <= kill;
    kidx_q <= snp_idx;
    ktag_q <= snp_tag;
  end

  // R6
  snoop_kill_chk: assert property (@(posedge clk) disable iff (rst)
    kill_q |-> !(vld_q[kidx_q] && (tag_q[kidx_q] == ktag_q)));
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
  import wtc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              lk_hit,
  output logic              fill_en,
  output logic              fill_valid,
  output logic [IDX_W-1:0]  ram_raddr,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  ctl_state_e        st_q;
  logic [ADDR_W-1:0] a_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;
  logic              pend_q;
  logic              rdy_q;
  logic [DATA_W-1:0] rdata_q;
  logic              breq_q;
  bus_cmd_e          bcmd_q;
  logic [ADDR_W-1:0] baddr_q;
  logic [DATA_W-1:0] bwd_q;
  logic              snp_same;
  logic              done;

  assign lk_idx    = a_q[IDX_W-1:0];
  assign lk_tag    = a_q[ADDR_W-1:IDX_W];
  assign ram_raddr = cpu_addr[IDX_W-1:0];
  assign snp_same  = snp_valid && snp_write && (snp_addr == a_q);
  assign done      = (st_q == ST_XFER) && bus_ack;
  assign fill_en   = done && !we_q;
  assign fill_valid = !(pend_q || snp_same);
  assign ram_we    = done && (!we_q || lk_hit);
  assign ram_wdata = we_q ? wd_q : bus_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      a_q     <= '0;
      we_q    <= 1'b0;
      wd_q    <= '0;
      pend_q  <= 1'b0;
      rdy_q   <= 1'b0;
      rdata_q <= '0;
      breq_q  <= 1'b0;
      bcmd_q  <= CMD_IDLE;
      baddr_q <= '0;
      bwd_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (cpu_req) begin
            a_q    <= cpu_addr;
            we_q   <= cpu_we;
            wd_q   <= cpu_wdata;
            pend_q <= 1'b0;
            st_q   <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (!we_q && lk_hit) begin
            rdata_q <= ram_rdata;
            rdy_q   <= 1'b1;
            st_q    <= ST_RESP;
          end else begin
            breq_q <= 1'b1;
            st_q   <= ST_ARB;
          end
        end
        ST_ARB: begin
          if (snp_same && !we_q) pend_q <= 1'b1;
          if (bus_gnt) begin
            bcmd_q  <= we_q ? CMD_WRITE : CMD_READ;
            baddr_q <= a_q;
            bwd_q   <= wd_q;
            st_q    <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (snp_same && !we_q) pend_q <= 1'b1;
          if (bus_ack) begin
            breq_q <= 1'b0;
            bcmd_q <= CMD_IDLE;
            rdy_q  <= 1'b1;
            if (!we_q) rdata_q <= bus_rdata;
            st_q   <= ST_RESP;
          end
        end
        default: begin
          rdy_q <= 1'b0;
          st_q  <= ST_IDLE;
        end
      endcase
    end
  end

  assign cpu_ready = rdy_q;
  assign cpu_rdata = rdata_q;
  assign bus_req   = breq_q;
  assign bus_cmd   = bcmd_q;
  assign bus_addr  = baddr_q;
  assign bus_wdata = bwd_q;

  // R9
  cmd_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_cmd != CMD_IDLE) |-> bus_gnt);
  // R9
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> bus_req);
  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
  // R10
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !bus_req);
  // R4
  store_to_bus_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOOK && we_q) |=> bus_req);
  // R3
  hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_LOOK && !we_q && lk_hit) |=> (!bus_req && bus_cmd == CMD_IDLE));
  // R5
  store_noalloc_chk: assert property (@(posedge clk) disable iff (rst)
    (done && we_q && !lk_hit) |=> !lk_hit);
  // R8
  raced_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_en && pend_q) |=> !lk_hit);
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache #(
  parameter int LINES  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag;
  logic              lk_hit;
  logic              fill_en;
  logic              fill_valid;
  logic [IDX_W-1:0]  ram_raddr;
  logic              ram_we;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;

  wtc_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .fill_en(fill_en), .fill_valid(fill_valid),
    .ram_raddr(ram_raddr), .ram_we(ram_we), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  wtc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
    .fill_en(fill_en), .fill_idx(lk_idx), .fill_tag(lk_tag), .fill_valid(fill_valid),
    .snp_en(snp_valid && snp_write),
    .snp_idx(snp_addr[IDX_W-1:0]), .snp_tag(snp_addr[ADDR_W-1:IDX_W])
  );

  wtc_data_store #(.LINES(LINES), .DATA_W(DATA_W)) u_data (
    .clk(clk), .we(ram_we), .waddr(lk_idx), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );
endmodule

// File: tb/wt_snoop_cache_bench.sv
`timescale 1ns/1ps
module wt_snoop_cache_bench;
  localparam int LINES = 16;
  localparam int DW    = 32;
  localparam int AW    = 12;
  localparam int IW    = 4;
  localparam int WORDS = 1 << AW;
  localparam int LAT   = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          req   [2];
  logic          we    [2];
  logic [AW-1:0] addr  [2];
  logic [DW-1:0] wd    [2];
  logic          rdy   [2];
  logic [DW-1:0] rd    [2];
  logic          breq  [2];
  logic          gnt   [2];
  logic [1:0]    bcmd  [2];
  logic [AW-1:0] baddr [2];
  logic [DW-1:0] bwd   [2];
  logic          ack   [2];
  logic          svld  [2];
  logic          swr   [2];
  logic [AW-1:0] saddr [2];

  logic [DW-1:0] mem [WORDS];
  logic          own_v, own_id, ack_q;
  logic [DW-1:0] mrdata;
  int            lat;
  int            rd_cnt [2];
  int            wr_cnt [2];
  int            viol;

  function automatic logic [DW-1:0] init_word(input int i);
    return (i * 32'h9E37_79B1) ^ 32'h0000_5A5A;
  endfunction

  for (genvar c = 0; c < 2; c++) begin : g_bus
    assign gnt[c]   = own_v && (own_id == c[0]);
    assign ack[c]   = ack_q && own_v && (own_id == c[0]);
    assign svld[c]  = ack_q && own_v && (own_id != c[0]);
    assign swr[c]   = (bcmd[1-c] == 2'b10);
    assign saddr[c] = baddr[1-c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_v <= 1'b0; own_id <= 1'b0; ack_q <= 1'b0; lat <= 0; mrdata <= '0;
      rd_cnt[0] <= 0; rd_cnt[1] <= 0; wr_cnt[0] <= 0; wr_cnt[1] <= 0;
      for (int i = 0; i < WORDS; i++) mem[i] <= init_word(i);
    end else begin
      ack_q <= 1'b0;
      if (!own_v) begin
        if (breq[0]) begin own_v <= 1'b1; own_id <= 1'b0; end
        else if (breq[1]) begin own_v <= 1'b1; own_id <= 1'b1; end
      end else if (!breq[own_id]) begin
        own_v <= 1'b0;
      end
      if (own_v && bcmd[own_id] != 2'b00 && !ack_q) begin
        if (lat == LAT - 1) begin
          lat   <= 0;
          ack_q <= 1'b1;
          if (bcmd[own_id] == 2'b01) begin
            mrdata <= mem[baddr[own_id]];
            rd_cnt[own_id] <= rd_cnt[own_id] + 1;
          end else begin
            mem[baddr[own_id]] <= bwd[own_id];
            wr_cnt[own_id] <= wr_cnt[own_id] + 1;
          end
        end else begin
          lat <= lat + 1;
        end
      end
    end
  end

  wt_snoop_cache #(.LINES(LINES), .DATA_W(DW), .ADDR_W(AW)) u_wt_snoop_cache (
    .clk(clk), .rst(rst), .cpu_req(req[0]), .cpu_we(we[0]), .cpu_addr(addr[0]),
    .cpu_wdata(wd[0]), .cpu_ready(rdy[0]), .cpu_rdata(rd[0]), .bus_req(breq[0]),
    .bus_gnt(gnt[0]), .bus_cmd(bcmd[0]), .bus_addr(baddr[0]), .bus_wdata(bwd[0]),
    .bus_ack(ack[0]), .bus_rdata(mrdata), .snp_valid(svld[0]), .snp_write(swr[0]),
    .snp_addr(saddr[0]));

  wt_snoop_cache #(.LINES(LINES), .DATA_W(DW), .ADDR_W(AW)) u_wt_snoop_cache_b (
    .clk(clk), .rst(rst), .cpu_req(req[1]), .cpu_we(we[1]), .cpu_addr(addr[1]),
    .cpu_wdata(wd[1]), .cpu_ready(rdy[1]), .cpu_rdata(rd[1]), .bus_req(breq[1]),
    .bus_gnt(gnt[1]), .bus_cmd(bcmd[1]), .bus_addr(baddr[1]), .bus_wdata(bwd[1]),
    .bus_ack(ack[1]), .bus_rdata(mrdata), .snp_valid(svld[1]), .snp_write(swr[1]),
    .snp_addr(saddr[1]));

  // protocol monitor for R9 and R10, sampled away from the clock edge
  logic prev_rdy [2];
  initial begin
    viol = 0; prev_rdy[0] = 1'b0; prev_rdy[1] = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        for (int c = 0; c < 2; c++) begin
          if (bcmd[c] != 2'b00 && !gnt[c]) viol++;
          if (rdy[c] && breq[c]) viol++;
          if (rdy[c] && prev_rdy[c]) viol++;
          prev_rdy[c] = rdy[c];
        end
        if (bcmd[0] != 2'b00 && bcmd[1] != 2'b00) viol++;
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [DW-1:0] ref_mem [WORDS];
  bit            sh_v [2][LINES];
  logic [AW-IW-1:0] sh_t [2][LINES];

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cpu_op(input int c, input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, output logic [DW-1:0] q);
    @(negedge clk);
    req[c] = 1'b1; we[c] = w; addr[c] = a; wd[c] = d;
    do @(negedge clk); while (!rdy[c]);
    q = rd[c];
    req[c] = 1'b0;
  endtask

  // predicted hit for a load, from the shadow line state
  function automatic bit exp_hit(input int c, input logic [AW-1:0] a);
    return sh_v[c][a[IW-1:0]] && (sh_t[c][a[IW-1:0]] == a[AW-1:IW]);
  endfunction

  task automatic do_op(input int c, input bit w, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input string tag);
    int r0, w0, o;
    bit h;
    logic [DW-1:0] q;
    o = 1 - c;
    r0 = rd_cnt[c]; w0 = wr_cnt[c];
    h = exp_hit(c, a);
    cpu_op(c, w, a, d, q);
    if (w) begin
      chk(wr_cnt[c] == w0 + 1 && rd_cnt[c] == r0, {tag, " store bus write"},
          wr_cnt[c] - w0, 1);
      ref_mem[a] = d;
      if (exp_hit(o, a)) sh_v[o][a[IW-1:0]] = 1'b0;
    end else begin
      chk(q === ref_mem[a], {tag, " load data"}, q, ref_mem[a]);
      chk(rd_cnt[c] == r0 + (h ? 0 : 1) && wr_cnt[c] == w0,
          h ? {tag, " hit without bus"} : {tag, " miss one bus read"},
          rd_cnt[c] - r0, h ? 0 : 1);
      if (!h) begin
        sh_v[c][a[IW-1:0]] = 1'b1;
        sh_t[c][a[IW-1:0]] = a[AW-1:IW];
      end
    end
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin
      req[c] = 0; we[c] = 0; addr[c] = '0; wd[c] = '0;
      for (int i = 0; i < LINES; i++) begin sh_v[c][i] = 0; sh_t[c][i] = '0; end
    end
    for (int i = 0; i < WORDS; i++) ref_mem[i] = init_word(i);
    void'($urandom(32'd1318));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    for (int c = 0; c < 2; c++)
      chk(!rdy[c] && !breq[c] && bcmd[c] == 2'b00, "R1 reset idle",
          {29'd0, rdy[c], breq[c], |bcmd[c]}, 0);

    // directed cases
    do_op(0, 0, 12'h010, 0, "R1 R2 cold");
    do_op(0, 0, 12'h010, 0, "R3");
    do_op(0, 0, 12'h110, 0, "R2 conflict");
    do_op(0, 0, 12'h010, 0, "R2 refill");
    do_op(0, 1, 12'h010, 32'hCAFE_0001, "R4 store hit");
    do_op(0, 0, 12'h010, 0, "R4 local copy");
    do_op(0, 1, 12'h025, 32'hBEEF_0002, "R5 store miss");
    do_op(0, 0, 12'h025, 0, "R5 no allocate");
    do_op(1, 0, 12'h010, 0, "R7 peer load");
    do_op(0, 0, 12'h010, 0, "R7 still hit");
    do_op(1, 1, 12'h010, 32'h1234_0003, "R6 peer store");
    do_op(0, 0, 12'h010, 0, "R6 refetch");

    // R8: cache A misses while cache B already owns the bus storing the same word
    begin
      logic [DW-1:0] qa, qb;
      int r0;
      r0 = rd_cnt[0];
      fork
        cpu_op(1, 1, 12'h037, 32'h7777_0004, qb);
        begin @(negedge clk); @(negedge clk); cpu_op(0, 0, 12'h037, 0, qa); end
      join
      ref_mem[12'h037] = 32'h7777_0004;
      chk(qa === 32'h7777_0004, "R8 raced fill data", qa, 32'h7777_0004);
      chk(rd_cnt[0] == r0 + 1, "R8 raced fill one read", rd_cnt[0] - r0, 1);
      sh_v[0][7] = 1'b0;
      do_op(0, 0, 12'h037, 0, "R8 line left invalid");
    end

    // constrained random mix over a small address pool
    for (int n = 0; n < 400; n++) begin
      int c;
      bit w;
      logic [AW-1:0] a;
      c = int'($urandom % 2);
      w = ($urandom % 10) < 4;
      a = {6'd0, 2'($urandom % 4), 2'd0, 2'($urandom % 4)};
      do_op(c, w, a, $urandom, w ? "R4 R5 random" : "R2 R3 R6 R7 random");
    end

    chk(viol == 0, "R9 R10 bus and ready protocol", viol, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule